// File: doc/BRIEF.md
# Dual-Edge Video Output Multiplexer

This block sits between a video compositor and the output pads. Once per pixel period it takes one 30-bit pixel word from the compositor. It then drives that word onto the output data bus, either unchanged or packed so that a narrow slice of the bus carries half of the pixel while the pixel clock is high and the other half while it is low. A video encoder that captures data on both pixel-clock edges can then take the whole pixel over fewer wires.

A 7-bit control word selects the behaviour:

- Bits [2:0] hold the output mode code.
- Bit 6 enables double-edge packing of 24-bit colour. It acts only with mode code 3'b100.
- Bit 5 enables double-edge packing of 16-bit YUV. It acts only with mode code 3'b010.
- Bits [4:3] are reserved.

In 24-bit packing, bus pins [16:5] alternate between the red plus upper-green field and the lower-green plus blue field. In 16-bit packing, pins [20:13] alternate between the chroma byte and the luma byte. Every other pin keeps the plain mapping.

The block runs from a clock at twice the pixel rate. A phase toggle produces the pixel clock, which therefore has an exact 50/50 duty cycle. The pixel clock and the data both leave registers clocked on the same edge, so they are aligned. The pixel word and the control word are captured together at each pixel boundary. A change to either never splits a pixel.

Top module: `dual_edge_vout`

## Requirements
- R1: While rst_ni is low, pclk_o and every bit of vdata_o are 0.
- R2: After reset, pclk_o toggles on every clk2x_i rising edge. The first edge after reset drives it to 1.
- R3: When packing is inactive, vdata_o equals the captured pixel word during both halves of the pixel. Packing is inactive when neither (ctrl_i[2:0]==3'b100 with ctrl_i[6]=1) nor (ctrl_i[2:0]==3'b010 with ctrl_i[5]=1) holds.
- R4: With ctrl_i[2:0]==3'b100 and ctrl_i[6]=1, vdata_o[16:5] carries the following. Both halves together rebuild word bits [29:12] and [9:2].
  - While pclk_o is high: {w[29:22], w[19:16]}.
  - While pclk_o is low: {w[15:12], w[9:2]}.
- R5: In 24-bit packing, vdata_o bits [29:17] and [4:0] equal the same bits of the word in both halves.
- R6: With ctrl_i[2:0]==3'b010 and ctrl_i[5]=1, vdata_o[20:13] carries w[19:12] while pclk_o is high and w[9:2] while it is low. All other bits equal the word's bits in both halves.
- R7: pix_word_i is captured once per pixel, on the clk2x_i edge that raises pclk_o. A change during the low half does not alter that pixel's output.
- R8: ctrl_i is captured on the same edge as the word. A change during the low half takes effect only from the next pixel.
- R9: The reserved bits ctrl_i[4:3] have no effect. An enable bit set for the mode that is not selected also has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Clock at twice the pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_word_i | input | WORD_W (30) | Compositor pixel word, held for one pixel period |
| ctrl_i | input | 7 | Mode code [2:0], reserved [4:3], 16-bit enable [5], 24-bit enable [6] |
| pclk_o | output | 1 | Pixel clock, divided by two from clk2x_i |
| vdata_o | output | WORD_W (30) | Output video data bus |

## Verification
The word and control presented before a pixel boundary appear at vdata_o as the high half on the next clk2x_i rising edge. The low half follows one edge later. The low half comes from the captured copy, so inputs changed after the boundary edge must not reach it. The bench drives inputs at falling clk2x_i edges while pclk_o is low. It reads the high half at the next falling edge and the low half at the one after, and it injects disturbing words and control values only between those two samples. Each packed pixel is also rebuilt from its two halves and compared with the original word over the bits the mode transports.

// File: rtl/dual_edge_pkg.sv
package dual_edge_pkg;
  localparam int CTRL_W = 7;
  localparam logic [2:0] MODE_C24 = 3'b100;
  localparam logic [2:0] MODE_Y16 = 3'b010;
  localparam int EN16_BIT = 5;
  localparam int EN24_BIT = 6;

  // sub-bus placement and widths
  localparam int SUB24_LSB = 5;
  localparam int SUB24_W   = 12;
  localparam int SUB16_LSB = 13;
  localparam int SUB16_W   = 8;

  // compositor field positions
  localparam int R_LSB  = 22;  // R[7:0]  -> w[29:22]
  localparam int GH_LSB = 16;  // G[7:4]  -> w[19:16]
  localparam int GL_LSB = 12;  // G[3:0]  -> w[15:12]
  localparam int B_LSB  = 2;   // B[7:0]  -> w[9:2]
  localparam int UV_LSB = 12;  // UV[7:0] -> w[19:12]

  typedef enum logic [1:0] {
    PK_PASS = 2'd0,
    PK_24   = 2'd1,
    PK_16   = 2'd2
  } pack_e;
endpackage

// File: rtl/dual_edge_decode.sv
module dual_edge_decode
  import dual_edge_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_i,
  output pack_e             pack_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^ctrl_i[4:3];

  always_comb begin
    pack_o = PK_PASS;
    if (ctrl_i[2:0] == MODE_C24 && ctrl_i[EN24_BIT]) pack_o = PK_24;
    else if (ctrl_i[2:0] == MODE_Y16 && ctrl_i[EN16_BIT]) pack_o = PK_16;
  end
endmodule

// File: rtl/dual_edge_phase.sv
module dual_edge_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph_o,
  output logic bound_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign ph_o    = ph_q;
  assign bound_o = ~ph_q;  // next edge starts a pixel
endmodule

// File: rtl/dual_edge_pack.sv
module dual_edge_pack
  import dual_edge_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic [WORD_W-1:0] word_i,
  input  pack_e             pack_i,
  input  logic              hi_i,
  output logic [WORD_W-1:0] bus_o
);
  logic [SUB24_W-1:0] hi24, lo24;
  logic [SUB16_W-1:0] hi16, lo16;

  assign hi24 = {word_i[R_LSB +: 8], word_i[GH_LSB +: 4]};
  assign lo24 = {word_i[GL_LSB +: 4], word_i[B_LSB +: 8]};
  assign hi16 = word_i[UV_LSB +: 8];
  assign lo16 = word_i[B_LSB +: 8];

  always_comb begin
    bus_o = word_i;
    unique case (pack_i)
      PK_24:   bus_o[SUB24_LSB +: SUB24_W] = hi_i ? hi24 : lo24;
      PK_16:   bus_o[SUB16_LSB +: SUB16_W] = hi_i ? hi16 : lo16;
      default: bus_o = word_i;
    endcase
  end
endmodule

// File: rtl/dual_edge_vout.sv
module dual_edge_vout
  import dual_edge_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic              clk2x_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] pix_word_i,
  input  logic [6:0]        ctrl_i,
  output logic              pclk_o,
  output logic [WORD_W-1:0] vdata_o
);
  logic              ph, bound;
  pack_e             pack_in, pack_q, src_pack;
  logic [WORD_W-1:0] word_q, src_word, bus_nx, vdata_q;

  dual_edge_phase u_phase (
    .clk_i  (clk2x_i),
    .rst_ni (rst_ni),
    .ph_o   (ph),
    .bound_o(bound)
  );

  dual_edge_decode u_dec (
    .ctrl_i(ctrl_i),
    .pack_o(pack_in)
  );

  // capture word and mode together at pixel start
  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      pack_q <= PK_PASS;
    end else if (bound) begin
      word_q <= pix_word_i;
      pack_q <= pack_in;
    end
  end

  // high half comes straight from inputs, low half from captured copy
  assign src_word = bound ? pix_word_i : word_q;
  assign src_pack = bound ? pack_in : pack_q;

  dual_edge_pack #(.WORD_W(WORD_W)) u_pack (
    .word_i(src_word),
    .pack_i(src_pack),
    .hi_i  (bound),
    .bus_o (bus_nx)
  );

  always_ff @(posedge clk2x_i or negedge rst_ni) begin
    if (!rst_ni) vdata_q <= '0;
    else         vdata_q <= bus_nx;
  end

  assign pclk_o  = ph;
  assign vdata_o = vdata_q;
endmodule

// File: rtl/dual_edge_vout_chk.sv
module dual_edge_vout_chk
  import dual_edge_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input logic              clk2x_i,
  input logic              rst_ni,
  input logic              pclk_o,
  input logic [WORD_W-1:0] vdata_o,
  input pack_e             pack_q
);
  assert_reset_quiet_R1: assert property (@(posedge clk2x_i)
    !rst_ni |-> (!pclk_o && vdata_o == '0));

  assert_pclk_toggle_R2: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    rst_ni |=> (pclk_o != $past(pclk_o)));

  assert_pass_stable_R3: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    ($fell(pclk_o) && pack_q == PK_PASS) |-> $stable(vdata_o));

  assert_c24_outside_R5: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    ($fell(pclk_o) && pack_q == PK_24) |->
      ($stable(vdata_o[WORD_W-1:17]) && $stable(vdata_o[4:0])));

  assert_y16_outside_R6: assert property (@(posedge clk2x_i) disable iff (!rst_ni)
    ($fell(pclk_o) && pack_q == PK_16) |->
      ($stable(vdata_o[WORD_W-1:21]) && $stable(vdata_o[12:0])));
endmodule

bind dual_edge_vout dual_edge_vout_chk #(.WORD_W(WORD_W)) u_chk (
  .clk2x_i(clk2x_i),
  .rst_ni (rst_ni),
  .pclk_o (pclk_o),
  .vdata_o(vdata_o),
  .pack_q (pack_q)
);

// File: tb/dual_edge_vout_bench.sv
module dual_edge_vout_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {class, ctrl, word}; class 0 pass, 1 packed 24-bit, 2 packed 16-bit
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 7'h00, 30'h12345678},
    {2'd1, 7'h44, 30'h3A5C96E1},
    {2'd2, 7'h22, 30'h0F0FA5A5},
    {2'd0, 7'h04, 30'h3FFF0000},
    {2'd0, 7'h24, 30'h2468ACE1},
    {2'd0, 7'h42, 30'h13579BDF},
    {2'd1, 7'h5C, 30'h3FFFFFFF},
    {2'd2, 7'h3A, 30'h00000001},
    {2'd1, 7'h44, 30'h00000000}
  };

  logic        clk2x, rst_n;
  logic [29:0] pix_word;
  logic [6:0]  ctrl;
  logic        pclk;
  logic [29:0] vdata;
  int checks = 0, errors = 0;
  bit done = 0;

  dual_edge_vout u_dual_edge_vout (
    .clk2x_i   (clk2x),
    .rst_ni    (rst_n),
    .pix_word_i(pix_word),
    .ctrl_i    (ctrl),
    .pclk_o    (pclk),
    .vdata_o   (vdata)
  );

  initial clk2x = 1'b0;
  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  function automatic logic [29:0] exp_half(input logic [29:0] w, input logic [1:0] cls,
                                           input logic hi);
    logic [29:0] r;
    r = w;
    if (cls == 2'd1) r[16:5]  = hi ? {w[29:22], w[19:16]} : {w[15:12], w[9:2]};
    if (cls == 2'd2) r[20:13] = hi ? w[19:12] : w[9:2];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [29:0] act,
                     input logic [29:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // precondition: at a falling edge with pclk low
  task automatic run_pixel(input logic [29:0] w, input logic [6:0] c, input logic [1:0] cls,
                           input logic [29:0] w_dist, input logic [6:0] c_dist,
                           input string req);
    logic [29:0] hi, lo, rec, mask, e;
    pix_word = w;
    ctrl     = c;
    @(negedge clk2x);
    hi = vdata;
    chk(pclk == 1'b1, "R2 pclk high half", {29'd0, pclk}, 30'd1);
    e = exp_half(w, cls, 1'b1);
    chk(hi == e, {req, " high"}, hi, e);
    pix_word = w_dist;
    ctrl     = c_dist;
    @(negedge clk2x);
    lo = vdata;
    chk(pclk == 1'b0, "R2 pclk low half", {29'd0, pclk}, 30'd0);
    e = exp_half(w, cls, 1'b0);
    chk(lo == e, {req, " low"}, lo, e);
    if (cls != 2'd0) begin
      rec = hi;
      if (cls == 2'd1) begin
        rec[29:22] = hi[16:9];
        rec[19:16] = hi[8:5];
        rec[15:12] = lo[16:13];
        rec[9:2]   = lo[12:5];
        mask = ~30'h00000C00;
      end else begin
        rec[19:12] = hi[20:13];
        rec[9:2]   = lo[20:13];
        mask = ~30'h00100C00;
      end
      chk((rec & mask) == (w & mask), {req, " rebuilt"}, rec & mask, w & mask);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk2x);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pix_word = 30'h3FFFFFFF;
    ctrl = 7'h44;
    repeat (3) @(negedge clk2x);
    // R1: reset state
    chk(pclk == 1'b0, "R1 pclk in reset", {29'd0, pclk}, 30'd0);
    chk(vdata == 30'd0, "R1 vdata in reset", vdata, 30'd0);
    rst_n = 1'b1;

    // table walk: R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      run_pixel(VEC[i][29:0], VEC[i][36:30], VEC[i][38:37],
                VEC[i][29:0], VEC[i][36:30], "R3/R4/R5/R6/R9 table");
    end

    // R7: word changed during low half is ignored
    run_pixel(30'h2AAAAAAA, 7'h44, 2'd1, 30'h15555555, 7'h44, "R7 word hold c24");
    run_pixel(30'h0C3C3C3C, 7'h22, 2'd2, 30'h33C3C3C3, 7'h22, "R7 word hold y16");
    // R8: control changed mid-pixel applies from next pixel
    run_pixel(30'h1E1E1E1E, 7'h44, 2'd1, 30'h1E1E1E1E, 7'h00, "R8 ctrl hold c24");
    run_pixel(30'h1E1E1E1E, 7'h00, 2'd0, 30'h1E1E1E1E, 7'h22, "R8 ctrl hold pass");
    run_pixel(30'h2D2D2D2D, 7'h22, 2'd2, 30'h2D2D2D2D, 7'h44, "R8 ctrl hold y16");
    run_pixel(30'h2D2D2D2D, 7'h44, 2'd1, 30'h2D2D2D2D, 7'h44, "R8 new ctrl c24");
    // R9: reserved bits alone, and cross enables, leave passthrough
    run_pixel(30'h0BADF00D, 7'h1C, 2'd0, 30'h0BADF00D, 7'h1C, "R9 reserved only");
    run_pixel(30'h0BADF00D, 7'h3C, 2'd0, 30'h0BADF00D, 7'h3C, "R9 wrong enable");

    // R1: asynchronous reset mid-stream
    pix_word = 30'h3FFFFFFF;
    ctrl = 7'h44;
    @(negedge clk2x);
    #1 rst_n = 1'b0;
    #1;
    chk(pclk == 1'b0, "R1 pclk async reset", {29'd0, pclk}, 30'd0);
    chk(vdata == 30'd0, "R1 vdata async reset", vdata, 30'd0);
    @(negedge clk2x);
    rst_n = 1'b1;
    run_pixel(30'h01234567, 7'h22, 2'd2, 30'h01234567, 7'h22, "R2/R6 after reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule